// File: doc/BRIEF.md
# General-Purpose Register File, Two Read Ports and One Write Port

This block holds the general-purpose registers of a small RISC core. There are 32 words of 32 bits each. Two read ports run independently and without a clock. Each one takes a 5-bit index and drives the selected word straight onto its data output. One write port takes a 5-bit index, a 32-bit word and an enable.

A write is stored on the falling edge of the clock. The decode stage can therefore read, in the next high phase, a value that the writeback stage stored in the middle of the same cycle. No bypass path is needed for that. Index 0 is the constant-zero register. It has no storage, it always reads as zero, and any write aimed at it is dropped. An active-low asynchronous reset clears every register to zero.

Top module: `gpr_file`

## Requirements
- R1: Each of indexes 1 to 31 keeps its own 32-bit value. A write to one index leaves every other index unchanged.
- R2: Both read ports are combinational. rd_a_data_o shows the word at rd_a_idx_i and rd_b_data_o shows the word at rd_b_idx_i. This holds at any time, including in the low phase just after a write.
- R3: When wr_en_i is high at a falling edge of clk_i, wr_data_i is stored at wr_idx_i. The new value can be read throughout the following high phase.
- R4: When wr_en_i is low at a falling edge, no register changes.
- R5: Index 0 reads as 32'h0 on both ports. A write with wr_idx_i equal to 0 is discarded.
- R6: While rst_ni is low, every register reads as zero, whatever the clock is doing.
- R7: When the same index is written twice, a read returns the value from the later write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes are stored on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Write index |
| wr_data_i | input | 32 | Write data |
| rd_a_idx_i | input | 5 | Read index, port A |
| rd_a_data_o | output | 32 | Read data, port A |
| rd_b_idx_i | input | 5 | Read index, port B |
| rd_b_data_o | output | 32 | Read data, port B |

## Verification
The bench writes all-ones to index 0 and checks that it still reads zero. A design that gave register 0 real storage would return the written value. It then writes with the enable low and checks that nothing changed, which catches decode logic that ignores the enable. It samples a read in the low phase right after a write, which exposes a design that stores on the rising edge or registers its reads. It also writes a distinct pattern to every index and reads each one back on both ports, and it pulses reset in the middle of the run. These catch a broken index decode and a reset that misses some entries.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned GPR_COUNT = 32;
  localparam int unsigned GPR_WIDTH = 32;
  localparam int unsigned GPR_IDX_W = $clog2(GPR_COUNT);
  localparam int unsigned GPR_RD_PORTS = 2;

  typedef logic [GPR_WIDTH-1:0] gpr_word_t;
  typedef logic [GPR_IDX_W-1:0] gpr_idx_t;
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode
  import gpr_pkg::*;
(
  input  logic               wr_en_i,
  input  gpr_idx_t           wr_idx_i,
  output logic [GPR_COUNT-1:1] sel_o
);
  // index 0 has no select line: writes to it are dropped
  for (genvar g = 1; g < GPR_COUNT; g++) begin : g_sel
    assign sel_o[g] = wr_en_i && (wr_idx_i == gpr_idx_t'(g));
  end
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage
  import gpr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [GPR_COUNT-1:1] sel_i,
  input  gpr_word_t            wr_data_i,
  output gpr_word_t            regs_o [GPR_COUNT]
);
  assign regs_o[0] = '0;

  for (genvar g = 1; g < GPR_COUNT; g++) begin : g_reg
    gpr_word_t q;
    // falling-edge commit: value is ready for the next high phase
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (sel_i[g]) q <= wr_data_i;
    end
    assign regs_o[g] = q;
  end
endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port
  import gpr_pkg::*;
(
  input  gpr_word_t regs_i [GPR_COUNT],
  input  gpr_idx_t  idx_i,
  output gpr_word_t data_o
);
  always_comb data_o = regs_i[idx_i];
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [GPR_IDX_W-1:0] wr_idx_i,
  input  logic [GPR_WIDTH-1:0] wr_data_i,
  input  logic [GPR_IDX_W-1:0] rd_a_idx_i,
  output logic [GPR_WIDTH-1:0] rd_a_data_o,
  input  logic [GPR_IDX_W-1:0] rd_b_idx_i,
  output logic [GPR_WIDTH-1:0] rd_b_data_o
);
  logic [GPR_COUNT-1:1] sel;
  gpr_word_t            regs [GPR_COUNT];
  gpr_idx_t             rd_idx  [GPR_RD_PORTS];
  gpr_word_t            rd_data [GPR_RD_PORTS];

  gpr_wr_decode u_dec (
    .wr_en_i (wr_en_i),
    .wr_idx_i(wr_idx_i),
    .sel_o   (sel)
  );

  gpr_storage u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel),
    .wr_data_i(wr_data_i),
    .regs_o   (regs)
  );

  assign rd_idx[0] = rd_a_idx_i;
  assign rd_idx[1] = rd_b_idx_i;

  for (genvar p = 0; p < GPR_RD_PORTS; p++) begin : g_rd
    gpr_rd_port u_rd (
      .regs_i(regs),
      .idx_i (rd_idx[p]),
      .data_o(rd_data[p])
    );
  end

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk
  import gpr_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [GPR_IDX_W-1:0] wr_idx_i,
  input logic [GPR_WIDTH-1:0] wr_data_i,
  input logic [GPR_IDX_W-1:0] rd_a_idx_i,
  input logic [GPR_WIDTH-1:0] rd_a_data_o,
  input logic [GPR_IDX_W-1:0] rd_b_idx_i,
  input logic [GPR_WIDTH-1:0] rd_b_data_o
);
  logic      lw_any, lw_valid;
  gpr_idx_t  lw_idx;
  gpr_word_t lw_data;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lw_any   <= 1'b0;
      lw_valid <= 1'b0;
      lw_idx   <= '0;
      lw_data  <= '0;
    end else begin
      lw_any   <= wr_en_i;
      lw_valid <= wr_en_i && (wr_idx_i != '0);
      lw_idx   <= wr_idx_i;
      lw_data  <= wr_data_i;
    end
  end

  // R5
  zero_read_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_idx_i == '0 |-> rd_a_data_o == '0);
  // R5
  zero_read_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_b_idx_i == '0 |-> rd_b_data_o == '0);
  // R3
  fresh_write_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lw_valid && rd_a_idx_i == lw_idx |-> rd_a_data_o == lw_data);
  // R3
  fresh_write_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lw_valid && rd_b_idx_i == lw_idx |-> rd_b_data_o == lw_data);
  // R4
  hold_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lw_any && $stable(rd_a_idx_i) |-> $stable(rd_a_data_o));
  // R4
  hold_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lw_any && $stable(rd_b_idx_i) |-> $stable(rd_b_data_o));
  // R6
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) && !lw_any |-> rd_a_data_o == '0 && rd_b_data_o == '0);
endmodule

bind gpr_file gpr_file_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_idx_i   (wr_idx_i),
  .wr_data_i  (wr_data_i),
  .rd_a_idx_i (rd_a_idx_i),
  .rd_a_data_o(rd_a_data_o),
  .rd_b_idx_i (rd_b_idx_i),
  .rd_b_data_o(rd_b_data_o)
);

// File: tb/gpr_file_test.sv
`timescale 1ns/100ps
module gpr_file_test;
  typedef struct packed {
    logic        we;
    logic [4:0]  widx;
    logic [31:0] wdata;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [31:0] exp_a;
    logic [31:0] exp_b;
  } vec_t;

  localparam int NV = 8;
  // R3 R4 R5 R7 table, applied after reset
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd5,  32'hA5A5A5A5, 5'd5,  5'd0,  32'hA5A5A5A5, 32'h0},
    '{1'b1, 5'd0,  32'hFFFFFFFF, 5'd0,  5'd5,  32'h0,        32'hA5A5A5A5},
    '{1'b0, 5'd5,  32'h12345678, 5'd5,  5'd5,  32'hA5A5A5A5, 32'hA5A5A5A5},
    '{1'b1, 5'd31, 32'hDEADBEEF, 5'd31, 5'd5,  32'hDEADBEEF, 32'hA5A5A5A5},
    '{1'b1, 5'd5,  32'h00000001, 5'd5,  5'd31, 32'h00000001, 32'hDEADBEEF},
    '{1'b1, 5'd1,  32'h80000000, 5'd1,  5'd1,  32'h80000000, 32'h80000000},
    '{1'b0, 5'd31, 32'h00000000, 5'd31, 5'd1,  32'hDEADBEEF, 32'h80000000},
    '{1'b1, 5'd16, 32'hCAFEF00D, 5'd16, 5'd0,  32'hCAFEF00D, 32'h0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [4:0]  rd_a_idx_i = '0;
  logic [31:0] rd_a_data_o;
  logic [4:0]  rd_b_idx_i = '0;
  logic [31:0] rd_b_data_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  gpr_file uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .wr_data_i(wr_data_i), .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
    .rd_b_idx_i(rd_b_idx_i), .rd_b_data_o(rd_b_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] d);
    @(posedge clk_i); #0.5;
    wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = d;
    @(negedge clk_i); #0.5;
    wr_en_i = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int i);
    return (i == 0) ? 32'h0 : (32'h01010101 * i) ^ 32'h5A000000;
  endfunction

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R6: values while reset is held
    repeat (2) @(posedge clk_i);
    #0.5;
    for (int i = 0; i < 32; i++) begin
      rd_a_idx_i = i[4:0]; rd_b_idx_i = 5'(31 - i); #0.1;
      chk("R6 reset state A", rd_a_data_o, 32'h0);
      chk("R6 reset state B", rd_b_data_o, 32'h0);
    end
    rst_ni = 1'b1;
    rd_a_idx_i = '0; rd_b_idx_i = '0;

    for (int i = 0; i < NV; i++) begin
      @(posedge clk_i); #0.5;
      wr_en_i = VECS[i].we; wr_idx_i = VECS[i].widx; wr_data_i = VECS[i].wdata;
      rd_a_idx_i = VECS[i].ra; rd_b_idx_i = VECS[i].rb;
      @(negedge clk_i); #0.5;
      wr_en_i = 1'b0;
      @(posedge clk_i); #0.5;
      chk($sformatf("R3 R4 R5 R7 vector %0d A", i), rd_a_data_o, VECS[i].exp_a);
      chk($sformatf("R3 R4 R5 R7 vector %0d B", i), rd_b_data_o, VECS[i].exp_b);
    end

    // R2: new value visible in the low phase right after the write
    rd_a_idx_i = 5'd9; rd_b_idx_i = 5'd9;
    wr(5'd9, 32'h0BADF00D);
    chk("R2 low-phase read A", rd_a_data_o, 32'h0BADF00D);
    chk("R2 low-phase read B", rd_b_data_o, 32'h0BADF00D);

    // R1: distinct pattern everywhere, read back on both ports
    for (int i = 0; i < 32; i++) wr(i[4:0], (i == 0) ? 32'hFFFFFFFF : pat(i));
    for (int i = 0; i < 32; i++) begin
      rd_a_idx_i = i[4:0]; rd_b_idx_i = 5'(31 - i); #0.1;
      chk("R1 R5 readback A", rd_a_data_o, pat(i));
      chk("R1 readback B", rd_b_data_o, pat(31 - i));
    end

    // R6: asynchronous reset mid-run, away from clock edges
    @(posedge clk_i); #1;
    rst_ni = 1'b0; #0.5;
    rd_a_idx_i = 5'd31; rd_b_idx_i = 5'd16; #0.1;
    chk("R6 async clear A", rd_a_data_o, 32'h0);
    chk("R6 async clear B", rd_b_data_o, 32'h0);
    @(posedge clk_i); #0.5;
    rst_ni = 1'b1;
    @(posedge clk_i); #0.5;
    rd_a_idx_i = 5'd5; #0.1;
    chk("R6 cleared after release", rd_a_data_o, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule